// File: doc/BRIEF.md
# Timed Configuration-Byte Readout Unit

This block sits beside the program-memory load path of a small processor core and lets software read its non-volatile configuration: the lock byte, three fuse bytes and a set of signature bytes. Software arms a read by writing the control register with the program-enable bit and one of two read-select bits set. For a short, fixed number of cycles after that write, a program-memory load returns a configuration byte instead of the flash word. The pointer address chooses which byte is returned.

The enable bits clear themselves. They clear once a load has used them, when a store arrives while they are armed, or when the window closes with no load. Software that polls the control register therefore sees them drop back to zero. Outside the window every load passes the flash data through unchanged.

The configuration and signature values come in as static inputs. A programmed bit is driven as 0 and an unprogrammed bit as 1, and the unit passes them on unaltered.

Top module: `cfg_read_unit`

## Requirements
- R1: After reset, ctrlRdData and loadData both read 0x00.
- R2: The control register has program-enable at bit 0, config-read at bit 3 and signature-read at bit 5. Every other bit reads 0. A write becomes visible on ctrlRdData in the cycle after the write.
- R3: A write that sets program-enable together with a read bit arms a window. A load strobed in the 1st, 2nd or 3rd cycle after that write returns a configuration byte instead of flash data.
- R4: During a config read, the two low pointer bits select the byte: 0 gives fuse-low, 1 gives lock, 2 gives extended fuse and 3 gives fuse-high. The upper pointer bits are ignored.
- R5: The lock byte carries the six lock inputs in bits 5..0, and its bits 7..6 read 1. The extended fuse byte carries its four inputs in bits 3..0, and its bits 7..4 read 1.
- R6: A load inside the window clears all three control bits. They read 0 from the next cycle.
- R7: If no load arrives by the 3rd cycle after the write, the control bits read 0 from the 4th cycle. A load in that 4th cycle returns flash data.
- R8: During a signature read, the byte index is the pointer's low 8 bits modulo NUM_SIG. Signature byte i sits at sigBytes[8i+7:8i]. When both read bits are set, the signature read wins.
- R9: When the register is not armed (program-enable clear, or no read bit set), a load returns flashData. Any bits that were written stay set.
- R10: A new arming write restarts the window, so the next cycle again counts as the 1st.
- R11: loadData is registered. It takes its new value in the cycle after a load strobe and holds its value in cycles with no load.
- R12: A store strobe while armed cancels the read. The control bits read 0 from the next cycle, and a later load returns flash data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control-register write strobe |
| ctrlWrData | input | 8 | Control-register write value |
| ctrlRdData | output | 8 | Control-register readback |
| loadStrobe | input | 1 | Program-memory load executes this cycle |
| storeStrobe | input | 1 | Store-program instruction executes this cycle |
| zPtr | input | 16 | Pointer address of the load |
| flashData | input | 8 | Byte read from program flash |
| loadData | output | 8 | Result of the most recent load |
| lockBits | input | 6 | Lock bits (0 = programmed) |
| fuseLow | input | 8 | Fuse low byte |
| fuseHigh | input | 8 | Fuse high byte |
| fuseExt | input | 4 | Extended fuse bits |
| sigBytes | input | 8*NUM_SIG | Signature bytes, byte i in bits 8i+7..8i |

## Verification
The bench uses the defaults NUM_SIG = 3 and WINDOW = 3. With these values, a pointer of 4 wraps to signature byte 1, which exercises the modulo index. They also put a load in the 4th cycle one cycle past a window short enough to walk cycle by cycle. The flash input is driven as a function of the pointer, so pass-through results can be told apart from every configuration value.

// File: rtl/cfg_read_pkg.sv
package cfg_read_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // a load executes this cycle
    logic useSig;   // return a signature byte
    logic useCfg;   // return a lock/fuse byte
  } rdStrobe_t;

  localparam int BIT_PROG = 0;
  localparam int BIT_CFG  = 3;
  localparam int BIT_SIG  = 5;
endpackage

// File: rtl/cfg_read_ctrl.sv
module cfg_read_ctrl
  import cfg_read_pkg::*;
#(
  parameter int WINDOW = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  logic       loadStrobe,
  input  logic       storeStrobe,
  output logic [7:0] ctrlRdData,
  output rdStrobe_t  strobes
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic progEn, cfgRd, sigRd, armed;
  logic [CNT_W-1:0] cycleCnt;

  assign armed = progEn & (cfgRd | sigRd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progEn   <= 1'b0;
      cfgRd    <= 1'b0;
      sigRd    <= 1'b0;
      cycleCnt <= '0;
    end else if (ctrlWrEn) begin
      progEn   <= ctrlWrData[BIT_PROG];
      cfgRd    <= ctrlWrData[BIT_CFG];
      sigRd    <= ctrlWrData[BIT_SIG];
      cycleCnt <= CNT_W'(1);
    end else if (armed) begin
      if (loadStrobe || storeStrobe || cycleCnt == CNT_W'(WINDOW)) begin
        progEn <= 1'b0;
        cfgRd  <= 1'b0;
        sigRd  <= 1'b0;
      end else begin
        cycleCnt <= cycleCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctrlRdData           = '0;
    ctrlRdData[BIT_PROG] = progEn;
    ctrlRdData[BIT_CFG]  = cfgRd;
    ctrlRdData[BIT_SIG]  = sigRd;
  end

  assign strobes.loadEn = loadStrobe;
  assign strobes.useSig = loadStrobe & armed & sigRd;
  assign strobes.useCfg = loadStrobe & armed & cfgRd & ~sigRd;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (cycleCnt >= CNT_W'(1) && cycleCnt <= CNT_W'(WINDOW)));

  // R6
  clear_on_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !ctrlWrEn && loadStrobe) |=> (ctrlRdData == 8'h00));

  // R7
  timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !ctrlWrEn && !loadStrobe && !storeStrobe && cycleCnt == CNT_W'(WINDOW))
      |=> (ctrlRdData == 8'h00));

  // R12
  store_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !ctrlWrEn && storeStrobe) |=> (ctrlRdData == 8'h00));

  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.useSig, strobes.useCfg}));
endmodule

// File: rtl/cfg_read_datapath.sv
module cfg_read_datapath
  import cfg_read_pkg::*;
#(
  parameter int NUM_SIG = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdStrobe_t            strobes,
  input  logic [15:0]          zPtr,
  input  logic [7:0]           flashData,
  input  logic [5:0]           lockBits,
  input  logic [7:0]           fuseLow,
  input  logic [7:0]           fuseHigh,
  input  logic [3:0]           fuseExt,
  input  logic [8*NUM_SIG-1:0] sigBytes,
  output logic [7:0]           loadData
);
  localparam int SIG_W = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1;

  logic [SIG_W-1:0] sigIdx;
  logic [7:0] sigSel, cfgSel, nextData;

  assign sigIdx = SIG_W'(32'(zPtr[7:0]) % NUM_SIG);

  always_comb begin
    sigSel = '0;
    for (int i = 0; i < NUM_SIG; i++)
      if (sigIdx == SIG_W'(i)) sigSel = sigBytes[8*i +: 8];
  end

  always_comb begin
    unique case (zPtr[1:0])
      2'd0:    cfgSel = fuseLow;
      2'd1:    cfgSel = {2'b11, lockBits};
      2'd2:    cfgSel = {4'hF, fuseExt};
      default: cfgSel = fuseHigh;
    endcase
  end

  assign nextData = strobes.useSig ? sigSel :
                    strobes.useCfg ? cfgSel : flashData;

  always_ff @(posedge clk) begin
    if (!rstN)              loadData <= '0;
    else if (strobes.loadEn) loadData <= nextData;
  end

  // R9
  flash_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && !strobes.useSig && !strobes.useCfg)
      |=> (loadData == $past(flashData)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadEn && !$past(!rstN)) |=> $stable(loadData));
endmodule

// File: rtl/cfg_read_unit.sv
module cfg_read_unit
  import cfg_read_pkg::*;
#(
  parameter int NUM_SIG = 3,
  parameter int WINDOW  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWrEn,
  input  logic [7:0]           ctrlWrData,
  output logic [7:0]           ctrlRdData,
  input  logic                 loadStrobe,
  input  logic                 storeStrobe,
  input  logic [15:0]          zPtr,
  input  logic [7:0]           flashData,
  output logic [7:0]           loadData,
  input  logic [5:0]           lockBits,
  input  logic [7:0]           fuseLow,
  input  logic [7:0]           fuseHigh,
  input  logic [3:0]           fuseExt,
  input  logic [8*NUM_SIG-1:0] sigBytes
);
  rdStrobe_t strobes;

  cfg_read_ctrl #(.WINDOW(WINDOW)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .loadStrobe(loadStrobe), .storeStrobe(storeStrobe),
    .ctrlRdData(ctrlRdData), .strobes(strobes)
  );

  cfg_read_datapath #(.NUM_SIG(NUM_SIG)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .zPtr(zPtr),
    .flashData(flashData), .lockBits(lockBits), .fuseLow(fuseLow),
    .fuseHigh(fuseHigh), .fuseExt(fuseExt), .sigBytes(sigBytes),
    .loadData(loadData)
  );
endmodule

// File: tb/cfg_read_unit_tb.sv
module cfg_read_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0, loadStrobe = 1'b0, storeStrobe = 1'b0;
  logic [7:0] ctrlWrData = '0, ctrlRdData, loadData;
  logic [15:0] zPtr = '0;
  logic [7:0] flashData;
  logic [5:0] lockBits = 6'h2C;
  logic [7:0] fuseLow = 8'h62, fuseHigh = 8'hDF;
  logic [3:0] fuseExt = 4'h9;
  logic [23:0] sigBytes = {8'h0F, 8'h93, 8'h1E};
  logic flashOverride = 1'b0;
  logic [7:0] flashForced = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz
  assign flashData = flashOverride ? flashForced : (zPtr[7:0] ^ 8'h5A);

  cfg_read_unit dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .loadStrobe(loadStrobe), .storeStrobe(storeStrobe),
    .zPtr(zPtr), .flashData(flashData), .loadData(loadData),
    .lockBits(lockBits), .fuseLow(fuseLow), .fuseHigh(fuseHigh),
    .fuseExt(fuseExt), .sigBytes(sigBytes)
  );

  // {ctrl, loadCycle, zPtr, expData, expCtrlAfter}
  localparam logic [47:0] VEC [13] = '{
    {8'h09, 8'd1, 16'h0000, 8'h62, 8'h00},  // R3 R4 fuse low
    {8'h09, 8'd2, 16'h0001, 8'hEC, 8'h00},  // R4 R5 lock
    {8'h09, 8'd3, 16'h0002, 8'hF9, 8'h00},  // R3 R5 ext, last cycle
    {8'h09, 8'd1, 16'h0003, 8'hDF, 8'h00},  // R4 fuse high
    {8'h09, 8'd4, 16'h0000, 8'h5A, 8'h00},  // R7 timeout -> flash
    {8'h21, 8'd1, 16'h0000, 8'h1E, 8'h00},  // R8 sig0
    {8'h21, 8'd3, 16'h0001, 8'h93, 8'h00},  // R8 sig1
    {8'h21, 8'd2, 16'h0002, 8'h0F, 8'h00},  // R8 sig2
    {8'h21, 8'd1, 16'h0004, 8'h93, 8'h00},  // R8 modulo wrap
    {8'h29, 8'd1, 16'h0003, 8'h1E, 8'h00},  // R8 priority
    {8'h08, 8'd1, 16'h0000, 8'h5A, 8'h08},  // R9 no program enable
    {8'h01, 8'd1, 16'h0001, 8'h5B, 8'h01},  // R9 no read bit
    {8'h09, 8'd1, 16'h0103, 8'hDF, 8'h00}   // R4 upper pointer bits ignored
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk); ctrlWrEn = 1'b0;
  endtask

  task automatic doLoad(input logic [15:0] z);
    loadStrobe = 1'b1; zPtr = z;
    @(negedge clk); loadStrobe = 1'b0;
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl reset", ctrlRdData, 8'h00);
    chk("R1 load reset", loadData, 8'h00);
    rstN = 1'b1;

    for (int v = 0; v < 13; v++) begin
      logic [47:0] e;
      e = VEC[v];
      doWrite(e[47:40]);
      for (int j = 1; j < int'(e[39:32]); j++) @(negedge clk);
      doLoad(e[31:16]);
      chk($sformatf("R3/R4/R8 vector %0d data", v), loadData, e[15:8]);
      chk($sformatf("R6/R7/R9 vector %0d ctrl", v), ctrlRdData, e[7:0]);
    end

    // R2 register layout and readback
    doWrite(8'hFF);
    chk("R2 readback", ctrlRdData, 8'h29);
    // R7 bits hold through cycle 3, clear in cycle 4
    @(negedge clk); @(negedge clk);
    chk("R7 still armed cycle 3", ctrlRdData, 8'h29);
    @(negedge clk);
    chk("R7 cleared cycle 4", ctrlRdData, 8'h00);

    // R10 rewrite restarts window
    doWrite(8'h09);
    @(negedge clk);
    doWrite(8'h09);
    @(negedge clk); @(negedge clk);
    doLoad(16'h0001);
    chk("R10 restart", loadData, 8'hEC);

    // R12 store cancels read
    doWrite(8'h09);
    storeStrobe = 1'b1;
    @(negedge clk); storeStrobe = 1'b0;
    chk("R12 ctrl cleared", ctrlRdData, 8'h00);
    doLoad(16'h0000);
    chk("R12 load flash", loadData, 8'h5A);

    // R11 hold without load
    flashOverride = 1'b1; flashForced = 8'hC3;
    @(negedge clk); @(negedge clk);
    chk("R11 hold", loadData, 8'h5A);
    doLoad(16'h0000);
    chk("R11 update", loadData, 8'hC3);

    // R6 cleared bits observed: a second load after use returns flash
    flashOverride = 1'b0;
    doWrite(8'h09);
    doLoad(16'h0003);
    doLoad(16'h0003);
    chk("R6 second load flash", loadData, 8'h59);

    finishRun();
  end
endmodule